// File: doc/BRIEF.md
# Serial-in LED channel driver controller

This block is the digital control core of a ten-channel LED sink driver. A host sends a bit stream on a serial data pin and marks each bit with a rising edge of a serial clock. The bits move through a ten-stage shift register. The last stage is brought out on a serial output, so several controllers can be chained in a daisy chain.

A level-sensitive transfer input copies the shift register into the channel latches. Each latch bit that is 1 turns its channel sink on. Two conditions force every channel off without touching the stored pattern: an active-high blank input, and a battery over-voltage flag that releases by itself. A power-on reset clears every register.

The serial clock, serial data and transfer inputs are asynchronous to the block clock. Each passes through a two-flop synchroniser, and shifting happens on the detected rising edge of the serial clock. The over-voltage flag has its own two-flop synchroniser. Blank gates the outputs combinationally.

Top module: `serial_led_ctrl`

## Requirements
- R1: Each rising edge of `sclk` moves the shift register up one stage, and the value on `sin` enters stage 0. Bit i of the register feeds channel i.
- R2: After a ten-bit frame has been shifted in and transferred, the first bit sent appears on `chan_on[9]` and the last bit sent appears on `chan_on[0]`.
- R3: `sout` always equals the final stage (stage 9). It therefore carries the bit sent ten serial clocks earlier, or 0 if fewer than ten bits have been shifted since reset.
- R4: While `xfer` is low, `chan_on` holds its value, even while new bits are being shifted in.
- R5: While `xfer` is high, the latches are transparent, so `chan_on` follows the shift register, including bits shifted during that time.
- R6: While `blank` is high, all of `chan_on` is 0 in the same cycle. Once `blank` is low, the latched pattern returns without a reload.
- R7: A high `ov_flag` forces all of `chan_on` to 0 starting two block clock edges later. When the flag clears, the channels resume the latched pattern by themselves, again two edges later.
- R8: Reset (`rst_n` low) clears the shift register, the latches and the synchronisers, so `sout` and every channel read 0.
- R9: A latch bit of 1 turns its channel on (`chan_on` bit high), and a latch bit of 0 leaves it off.
- R10: While `sclk` has no rising edge (held high or held low), the shift register does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| sclk | input | 1 | Serial clock; shifting happens on its rising edge |
| sin | input | 1 | Serial data in |
| xfer | input | 1 | Transfer input; latches are transparent while it is high |
| blank | input | 1 | Active-high blank; forces all channels off |
| ov_flag | input | 1 | Battery over-voltage flag (digital) |
| sout | output | 1 | Daisy-chain serial output, from stage 9 |
| chan_on | output | 10 | Channel sink enables; 1 = on |

## Verification
A shift becomes visible on `sout` three block clock edges after `sclk` rises: two synchroniser flops plus the edge detector. The bench holds each serial clock phase for four edges and samples one time unit after the last of them.

A change on `xfer` reaches `chan_on` two edges after it is driven, and the bench waits three edges. `ov_flag` takes exactly two edges, so the bench checks that the channels are still lit after one edge and are dark after the second. `blank` is combinational and is checked one time unit after it changes.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int unsigned CH_DEFAULT   = 10;
  localparam int unsigned SYNC_DEFAULT = 2;

  typedef enum logic [1:0] {
    GATE_OPEN  = 2'b00,
    GATE_BLANK = 2'b01,
    GATE_OVER  = 2'b10,
    GATE_BOTH  = 2'b11
  } gate_cause_e;

  function automatic gate_cause_e gate_cause(input logic blank_i, input logic over_i);
    return gate_cause_e'({over_i, blank_i});
  endfunction
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sld_shift.sv
module sld_shift #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         din_s,
  output logic         adv_evt,
  output logic [N-1:0] sreg
);
  logic sclk_d;

  function automatic logic [N-1:0] shift_step(input logic [N-1:0] cur, input logic b);
    return {cur[N-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign adv_evt = sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg <= '0;
    else if (adv_evt) sreg <= shift_step(sreg, din_s);
  end

  AST_SHIFT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> sreg == {$past(sreg[N-2:0]), $past(din_s)}); // R1
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_evt |=> $stable(sreg)); // R10
endmodule

// File: rtl/sld_latch.sv
module sld_latch #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer_s,
  input  logic [N-1:0] sreg,
  output logic [N-1:0] lat_q
);
  logic [N-1:0] hold_q;

  assign lat_q = xfer_s ? sreg : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= lat_q;
  end

  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_s |=> (xfer_s || $stable(lat_q))); // R4
  AST_LAT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_s |-> lat_q == sreg); // R5
endmodule

// File: rtl/sld_gate.sv
module sld_gate #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blank,
  input  logic         over_s,
  input  logic [N-1:0] lat_q,
  output logic [N-1:0] chan_on
);
  import sld_pkg::*;

  gate_cause_e cause;
  logic        enable;

  assign cause  = gate_cause(blank, over_s);
  assign enable = (cause == GATE_OPEN);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ch
      assign chan_on[g] = enable & lat_q[g];
    end
  endgenerate

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> chan_on == '0); // R6
  AST_OVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    over_s |-> chan_on == '0); // R7
  AST_PASS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank && !over_s) |-> chan_on == lat_q); // R9
endmodule

// File: rtl/serial_led_ctrl.sv
module serial_led_ctrl #(
  parameter int unsigned CHANNELS    = sld_pkg::CH_DEFAULT,
  parameter int unsigned SYNC_STAGES = sld_pkg::SYNC_DEFAULT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                sin,
  input  logic                xfer,
  input  logic                blank,
  input  logic                ov_flag,
  output logic                sout,
  output logic [CHANNELS-1:0] chan_on
);
  localparam int unsigned LAST = CHANNELS - 1;

  logic [2:0]          ser_s;
  logic                sclk_s, din_s, xfer_s, over_s, adv_evt;
  logic [CHANNELS-1:0] sreg, lat_q;

  sld_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ser_sync (
    .clk(clk), .rst_n(rst_n), .d({xfer, sin, sclk}), .q(ser_s));
  assign sclk_s = ser_s[0];
  assign din_s  = ser_s[1];
  assign xfer_s = ser_s[2];

  sld_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ov_sync (
    .clk(clk), .rst_n(rst_n), .d(ov_flag), .q(over_s));

  sld_shift #(.N(CHANNELS)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .din_s(din_s),
    .adv_evt(adv_evt), .sreg(sreg));

  sld_latch #(.N(CHANNELS)) u_latch (
    .clk(clk), .rst_n(rst_n), .xfer_s(xfer_s), .sreg(sreg), .lat_q(lat_q));

  sld_gate #(.N(CHANNELS)) u_gate (
    .clk(clk), .rst_n(rst_n), .blank(blank), .over_s(over_s),
    .lat_q(lat_q), .chan_on(chan_on));

  assign sout = sreg[LAST];

  AST_SOUT_CH9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_s && !blank && !over_s) |-> sout == chan_on[LAST]); // R3
  AST_SOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> sout == $past(sreg[LAST-1])); // R3
endmodule

// File: tb/serial_led_ctrl_tb_top.sv
module serial_led_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 0, sin = 0, xfer = 0, blank = 0, ov_flag = 0;
  logic sout;
  logic [N-1:0] chan_on;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [N-1:0] m_sreg = '0, m_lat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_led_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin), .xfer(xfer),
    .blank(blank), .ov_flag(ov_flag), .sout(sout), .chan_on(chan_on));

  function automatic logic [N-1:0] exp_chan(input logic [N-1:0] lat, input logic bl, input logic ov);
    return (bl || ov) ? '0 : lat;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_bit(input logic b);
    sin = b; sclk = 1'b1;
    edges(4);
    m_sreg = {m_sreg[N-2:0], b};
    if (xfer) m_lat = m_sreg;
    sclk = 1'b0;
    edges(4);
  endtask

  task automatic xfer_pulse();
    xfer = 1'b1; edges(3);
    m_lat = m_sreg;
    xfer = 1'b0; edges(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sclk = 0; sin = 0; xfer = 0; ov_flag = 0;
    edges(2);
    m_sreg = '0; m_lat = '0;
    chk("R8 reset chan", chan_on, '0);
    chk("R8 reset sout", {9'b0, sout}, '0);
    rst_n = 1'b1; edges(1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] fr;
    void'($urandom(32'h5EED));
    do_reset();

    // R2, R9: directed frame, first bit to channel 9
    fr = 10'b1000000011;
    for (int i = N-1; i >= 0; i--) shift_bit(fr[i]);
    chk("R4 no xfer yet", chan_on, '0);
    xfer_pulse();
    chk("R2 frame order", chan_on, fr);
    chk("R9 one is on", {9'b0, chan_on[9]}, 10'd1);
    chk("R3 sout is stage9", {9'b0, sout}, {9'b0, fr[9]});

    // R10: sclk held high, no further edges
    sin = 1'b0; sclk = 1'b1; edges(6);
    m_sreg = {m_sreg[N-2:0], 1'b0};
    edges(10);
    chk("R10 hold high", {9'b0, sout}, {9'b0, m_sreg[9]});
    sclk = 1'b0; edges(10);
    xfer_pulse();
    chk("R10 one shift only", chan_on, m_sreg);

    // R4: shifting with xfer low keeps outputs
    fr = chan_on;
    for (int i = 0; i < 4; i++) shift_bit(1'b1);
    chk("R4 hold while shifting", chan_on, fr);

    // R5: transparent while xfer high
    xfer = 1'b1; edges(3); m_lat = m_sreg;
    chk("R5 open", chan_on, m_sreg);
    shift_bit(1'b0);
    chk("R5 follows shift", chan_on, m_sreg);
    xfer = 1'b0; edges(3);

    // R6: blank
    blank = 1'b1; #1;
    chk("R6 blank off", chan_on, '0);
    shift_bit(1'b1);
    blank = 1'b0; #1;
    chk("R6 release no reload", chan_on, m_lat);

    // R7: over-voltage, two-edge latency
    ov_flag = 1'b1; edges(1);
    chk("R7 one edge still on", chan_on, m_lat);
    edges(1);
    chk("R7 two edges off", chan_on, '0);
    ov_flag = 1'b0; edges(2);
    chk("R7 self resume", chan_on, m_lat);

    // R8: reset mid-run, then R3 zeros until full frame
    do_reset();
    for (int i = 0; i < N-1; i++) begin
      shift_bit(1'b1);
      chk("R3 zeros after reset", {9'b0, sout}, '0);
    end
    shift_bit(1'b1);
    chk("R3 full frame out", {9'b0, sout}, 10'd1);

    // random frames with random gating
    for (int it = 0; it < 30; it++) begin
      fr = N'($urandom);
      for (int i = N-1; i >= 0; i--) begin
        shift_bit(fr[i]);
        chk("R1 R3 sout track", {9'b0, sout}, {9'b0, m_sreg[9]});
      end
      xfer_pulse();
      chk("R2 random frame", chan_on, fr);
      blank = 1'($urandom); ov_flag = 1'($urandom);
      edges(2);
      chk("R6 R7 random gate", chan_on, exp_chan(m_lat, blank, ov_flag));
      blank = 0; ov_flag = 0; edges(2);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule